// File: doc/BRIEF.md
# Host Port Ready and Wait-State Generator

This block produces the ready handshake for an 8-bit host port whose memory accesses share an internal bus with a DMA engine. The host chip select and two data strobes are merged into one internal access strobe. The strobe is live only while the select is low and at least one data strobe is low. When an accepted access ends, the block drops ready for a busy window and then raises it again. The length of the window depends on what the access was and on how busy the DMA engine was when the access ended.

Memory words move as two bytes. A read fetches the word on its first byte, and a write commits the word on its second byte. Only those bytes open a memory window, so the other byte of each pair completes without a wait. Accesses to the control register never wait, except for a write that sets either interrupt request bit. That write opens a short window of its own. The block also holds the host interrupt flag and the core interrupt flag, along with the remaining control-register fields. All of its state changes on the rising clock edge.

Top module: `hpr_ready_gen`

## Requirements
- R1: An access takes place only while `host_sel_n` is low and at least one of `strb_a_n` or `strb_b_n` is low. Data-strobe activity while `host_sel_n` is high starts no busy window, and either data strobe alone can carry an access.
- R2: `rdy` is high whenever `host_sel_n` is high, even in the middle of a busy window.
- R3: A memory access that ends with `dma_act`=0 holds `rdy` low for exactly LEN_IDLE (default 5) clock cycles after the clock edge that sees the strobe end.
- R4: A memory access that ends with `dma_act`=1 and `dma_32`=0 holds `rdy` low for exactly LEN_D16 (default 9) cycles.
- R5: A memory access that ends with `dma_act`=1 and `dma_32`=1 holds `rdy` low for exactly LEN_D32 (default 13) cycles.
- R6: A control write (`reg_sel`=1, `rd_wr`=0) with bit 0 or bit 1 of `wdata` set holds `rdy` low for LEN_IRQ (default 3) cycles. Bit 0 = 1 sets `dsp_irq`, and bit 1 = 1 clears `host_irq`.
- R7: Any other control write, and any control read, leaves `rdy` high. Every accepted control write loads `ctl_cfg` with `wdata`, with bits 0 and 1 forced to zero.
- R8: A memory read (`rd_wr`=1) opens a window only on its first byte (`byte2`=0). A memory write (`rd_wr`=0) opens one only on its second byte (`byte2`=1). The other byte of each pair completes with `rdy` staying high.
- R9: A strobe that begins while `rdy` is low is not accepted. It does not lengthen the window, it starts no window when it ends, and it has no effect on the interrupt flags or on `ctl_cfg`.
- R10: `dma_act` and `dma_32` are sampled on the edge that sees the strobe end. Changes to them during the window do not alter its length.
- R11: A one-cycle `core_irq` pulse sets `host_irq` on the next edge, and `dsp_ack` clears `dsp_irq` on the next edge. If a set and a clear of the same flag arrive together, the set wins.
- R12: A synchronous active-high `rst` clears the busy window and both interrupt flags, clears `ctl_cfg`, and leaves `rdy` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| host_sel_n | input | 1 | Host chip select, active low |
| strb_a_n | input | 1 | First host data strobe, active low |
| strb_b_n | input | 1 | Second host data strobe, active low |
| rd_wr | input | 1 | Access direction: 1 read, 0 write |
| reg_sel | input | 1 | 1 selects the control register, 0 selects memory |
| byte2 | input | 1 | 0 first byte, 1 second byte of a word |
| wdata | input | 8 | Host write data |
| dma_act | input | 1 | DMA engine is using the shared bus |
| dma_32 | input | 1 | DMA engine runs 32-bit transfers (else 16-bit) |
| core_irq | input | 1 | Core request to interrupt the host |
| dsp_ack | input | 1 | Core acknowledge of its own interrupt flag |
| rdy | output | 1 | Ready to the host, low during a busy window |
| host_irq | output | 1 | Interrupt flag toward the host |
| dsp_irq | output | 1 | Interrupt flag toward the core |
| ctl_cfg | output | 8 | Non-interrupt control-register fields |

## Verification
The bench builds the block with its default window lengths of 5, 9, 13 and 3 cycles and an 8-bit data bus. These short windows keep every access measurable cycle by cycle. The bench sweeps every combination of direction, register or memory target, byte position, the three DMA states and four write-data patterns, and checks each against an arithmetic model of the window length. Directed sequences then cover the cases a sweep cannot reach: a strobe landing inside a window, DMA inputs changing mid-window, chip select lifting mid-window, and reset during a window.

// File: rtl/hpr_pkg.sv
package hpr_pkg;

    localparam int HPR_DW   = 8;
    localparam int DSP_BIT  = 0;
    localparam int HOST_BIT = 1;

    typedef enum logic [1:0] {
        WIN_NONE = 2'd0,
        WIN_MEM  = 2'd1,
        WIN_IRQ  = 2'd2
    } win_kind_e;

    typedef struct packed {
        logic              rd;
        logic              reg_sel;
        logic              byte2;
        logic [HPR_DW-1:0] wdata;
    } acc_req_t;

    typedef struct packed {
        win_kind_e         kind;
        logic              set_dsp;
        logic              clr_host;
        logic              cfg_wr;
        logic [HPR_DW-1:0] cfg_val;
    } acc_dec_t;

    // Classify a finished access: which window it opens and what it changes.
    function automatic acc_dec_t decode_access(acc_req_t r);
        acc_dec_t d;
        d      = '0;
        d.kind = WIN_NONE;
        if (r.reg_sel) begin
            if (!r.rd) begin
                d.cfg_wr            = 1'b1;
                d.cfg_val           = r.wdata;
                d.cfg_val[DSP_BIT]  = 1'b0;
                d.cfg_val[HOST_BIT] = 1'b0;
                d.set_dsp           = r.wdata[DSP_BIT];
                d.clr_host          = r.wdata[HOST_BIT];
                if (r.wdata[DSP_BIT] || r.wdata[HOST_BIT])
                    d.kind = WIN_IRQ;
            end
        end else if (r.rd != r.byte2) begin
            // read fetches on byte one, write commits on byte two
            d.kind = WIN_MEM;
        end
        return d;
    endfunction

    function automatic int max_of4(int a, int b, int c, int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/hpr_strobe.sv
module hpr_strobe (
    input  logic clk,
    input  logic rst,
    input  logic host_sel_n,
    input  logic strb_a_n,
    input  logic strb_b_n,
    output logic start,
    output logic fin
);

    logic strb;
    logic strb_q;

    // live only with select low and at least one data strobe low
    assign strb = ~(host_sel_n | (strb_a_n & strb_b_n));

    always_ff @(posedge clk) begin
        if (rst) strb_q <= 1'b0;
        else     strb_q <= strb;
    end

    assign start = strb & ~strb_q;
    assign fin   = ~strb & strb_q;

endmodule

// File: rtl/hpr_busy_timer.sv
module hpr_busy_timer
    import hpr_pkg::*;
#(
    parameter int LEN_IDLE = 5,
    parameter int LEN_D16  = 9,
    parameter int LEN_D32  = 13,
    parameter int LEN_IRQ  = 3,
    parameter int CNT_W    = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  win_kind_e        kind,
    input  logic             dma_act,
    input  logic             dma_32,
    output logic [CNT_W-1:0] cnt,
    output logic             busy
);

    logic [CNT_W-1:0] len_sel;

    always_comb begin
        unique case (kind)
            WIN_IRQ: len_sel = CNT_W'(LEN_IRQ);
            WIN_MEM: begin
                if (!dma_act)    len_sel = CNT_W'(LEN_IDLE);
                else if (dma_32) len_sel = CNT_W'(LEN_D32);
                else             len_sel = CNT_W'(LEN_D16);
            end
            default: len_sel = '0;
        endcase
    end

    // length is fixed at load; DMA inputs are not looked at again
    always_ff @(posedge clk) begin
        if (rst)             cnt <= '0;
        else if (load)       cnt <= len_sel;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign busy = (cnt != '0);

endmodule

// File: rtl/hpr_ready_gen.sv
module hpr_ready_gen
    import hpr_pkg::*;
#(
    parameter int LEN_IDLE = 5,
    parameter int LEN_D16  = 9,
    parameter int LEN_D32  = 13,
    parameter int LEN_IRQ  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_sel_n,
    input  logic              strb_a_n,
    input  logic              strb_b_n,
    input  logic              rd_wr,
    input  logic              reg_sel,
    input  logic              byte2,
    input  logic [HPR_DW-1:0] wdata,
    input  logic              dma_act,
    input  logic              dma_32,
    input  logic              core_irq,
    input  logic              dsp_ack,
    output logic              rdy,
    output logic              host_irq,
    output logic              dsp_irq,
    output logic [HPR_DW-1:0] ctl_cfg
);

    localparam int LEN_MAX = max_of4(LEN_IDLE, LEN_D16, LEN_D32, LEN_IRQ);
    localparam int CNT_W   = $clog2(LEN_MAX + 1);

    logic             start;
    logic             fin;
    logic             acc_q;
    logic             commit;
    logic             tm_load;
    logic             irq_load;
    logic             busy;
    logic [CNT_W-1:0] busy_cnt;
    acc_req_t         req;
    acc_dec_t         dec;

    hpr_strobe u_strobe (
        .clk        (clk),
        .rst        (rst),
        .host_sel_n (host_sel_n),
        .strb_a_n   (strb_a_n),
        .strb_b_n   (strb_b_n),
        .start      (start),
        .fin        (fin)
    );

    always_comb begin
        req.rd      = rd_wr;
        req.reg_sel = reg_sel;
        req.byte2   = byte2;
        req.wdata   = wdata;
        dec         = decode_access(req);
    end

    // an access counts only if it began while no window was running
    always_ff @(posedge clk) begin
        if (rst)                acc_q <= 1'b0;
        else if (start && !busy) acc_q <= 1'b1;
        else if (fin)           acc_q <= 1'b0;
    end

    assign commit   = fin & acc_q;
    assign tm_load  = commit && (dec.kind != WIN_NONE);
    assign irq_load = commit && (dec.kind == WIN_IRQ);

    hpr_busy_timer #(
        .LEN_IDLE (LEN_IDLE),
        .LEN_D16  (LEN_D16),
        .LEN_D32  (LEN_D32),
        .LEN_IRQ  (LEN_IRQ),
        .CNT_W    (CNT_W)
    ) u_timer (
        .clk     (clk),
        .rst     (rst),
        .load    (tm_load),
        .kind    (dec.kind),
        .dma_act (dma_act),
        .dma_32  (dma_32),
        .cnt     (busy_cnt),
        .busy    (busy)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            host_irq <= 1'b0;
            dsp_irq  <= 1'b0;
            ctl_cfg  <= '0;
        end else begin
            if (core_irq)                    host_irq <= 1'b1;
            else if (commit && dec.clr_host) host_irq <= 1'b0;

            if (commit && dec.set_dsp)       dsp_irq <= 1'b1;
            else if (dsp_ack)                dsp_irq <= 1'b0;

            if (commit && dec.cfg_wr)        ctl_cfg <= dec.cfg_val;
        end
    end

    assign rdy = host_sel_n | ~busy;

endmodule

// File: rtl/hpr_ready_chk.sv
module hpr_ready_chk #(
    parameter int CNT_W   = 4,
    parameter int LEN_IRQ = 3,
    parameter int LEN_MAX = 13
) (
    input logic             clk,
    input logic             rst,
    input logic             host_sel_n,
    input logic             rdy,
    input logic             start,
    input logic             busy,
    input logic             acc_q,
    input logic             irq_load,
    input logic [CNT_W-1:0] cnt,
    input logic             core_irq,
    input logic             host_irq
);

    AST_SEL_HIGH_READY: assert property (@(posedge clk) disable iff (rst)
        host_sel_n |-> rdy);  // R2

    AST_WINDOW_COUNTS_DOWN: assert property (@(posedge clk) disable iff (rst)
        (cnt != '0) |=> (cnt == $past(cnt) - CNT_W'(1)));  // R3

    AST_WINDOW_BOUND: assert property (@(posedge clk) disable iff (rst)
        (int'(cnt) <= LEN_MAX));  // R5

    AST_IRQ_WINDOW_LEN: assert property (@(posedge clk) disable iff (rst)
        irq_load |=> (cnt == CNT_W'(LEN_IRQ)));  // R6

    AST_BUSY_REJECTS: assert property (@(posedge clk) disable iff (rst)
        (start && busy) |=> !acc_q);  // R9

    AST_HOST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (rst)
        $rose(host_irq) |-> $past(core_irq));  // R11

endmodule

bind hpr_ready_gen hpr_ready_chk #(
    .CNT_W   (CNT_W),
    .LEN_IRQ (LEN_IRQ),
    .LEN_MAX (LEN_MAX)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .host_sel_n (host_sel_n),
    .rdy        (rdy),
    .start      (start),
    .busy       (busy),
    .acc_q      (acc_q),
    .irq_load   (irq_load),
    .cnt        (busy_cnt),
    .core_irq   (core_irq),
    .host_irq   (host_irq)
);

// File: tb/hpr_ready_gen_test.sv
module hpr_ready_gen_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       host_sel_n = 1'b1;
    logic       strb_a_n = 1'b1;
    logic       strb_b_n = 1'b1;
    logic       rd_wr = 1'b1;
    logic       reg_sel = 1'b0;
    logic       byte2 = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic       dma_act = 1'b0;
    logic       dma_32 = 1'b0;
    logic       core_irq = 1'b0;
    logic       dsp_ack = 1'b0;
    logic       rdy;
    logic       host_irq;
    logic       dsp_irq;
    logic [7:0] ctl_cfg;

    int errors = 0;
    int checks = 0;

    always #4 clk = ~clk;

    hpr_ready_gen uut (
        .clk(clk), .rst(rst), .host_sel_n(host_sel_n),
        .strb_a_n(strb_a_n), .strb_b_n(strb_b_n),
        .rd_wr(rd_wr), .reg_sel(reg_sel), .byte2(byte2), .wdata(wdata),
        .dma_act(dma_act), .dma_32(dma_32), .core_irq(core_irq),
        .dsp_ack(dsp_ack), .rdy(rdy), .host_irq(host_irq),
        .dsp_irq(dsp_irq), .ctl_cfg(ctl_cfg)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int exp_len(input logic rd, input logic rg, input logic b2,
                                   input logic [7:0] wd, input logic da, input logic dw);
        if (rg) return (!rd && (wd[0] || wd[1])) ? 3 : 0;
        if (rd == b2) return 0;
        if (!da) return 5;
        return dw ? 13 : 9;
    endfunction

    // Counts cycles with rdy low; hook adds stimulus inside the window.
    task automatic measure(output int n, input int hook);
        n = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (rdy) break;
            n++;
            if (hook == 1 && n == 1) begin
                reg_sel = 1'b1; rd_wr = 1'b0; wdata = 8'hE1; strb_a_n = 1'b0;
            end
            if (hook == 1 && n == 2) strb_a_n = 1'b1;
            if (hook == 2 && n == 1) begin dma_act = 1'b0; dma_32 = 1'b0; end
            if (hook == 3 && n == 2) begin
                host_sel_n = 1'b1;
                #1 chk("R2 rdy with select high", int'(rdy), 1);
                host_sel_n = 1'b0;
            end
        end
    endtask

    task automatic access(input logic rd, input logic rg, input logic b2,
                          input logic [7:0] wd, input logic da, input logic dw,
                          input logic use_b, input int hook, output int n);
        @(negedge clk);
        rd_wr = rd; reg_sel = rg; byte2 = b2; wdata = wd;
        dma_act = da; dma_32 = dw;
        if (use_b) strb_b_n = 1'b0; else strb_a_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        strb_a_n = 1'b1; strb_b_n = 1'b1;
        if (hook == 2) begin dma_act = 1'b1; dma_32 = 1'b1; end
        measure(n, hook);
    endtask

    task automatic finish_run;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #1_000_000;
        errors++; checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        finish_run();
    end

    initial begin
        int n;
        host_sel_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R12 rdy in reset", int'(rdy), 1);
        rst = 1'b0;
        @(negedge clk);
        chk("R12 host_irq after reset", int'(host_irq), 0);
        chk("R12 dsp_irq after reset", int'(dsp_irq), 0);
        chk("R12 ctl_cfg after reset", int'(ctl_cfg), 0);

        // Sweep: direction x target x byte x DMA state x write pattern
        for (int rd = 0; rd < 2; rd++)
            for (int rg = 0; rg < 2; rg++)
                for (int b2 = 0; b2 < 2; b2++)
                    for (int dc = 0; dc < 3; dc++)
                        for (int ws = 0; ws < 4; ws++) begin
                            logic [7:0] wd;
                            logic da, dw;
                            int e;
                            string tag;
                            wd = (ws == 0) ? 8'h00 : (ws == 1) ? 8'h01 :
                                 (ws == 2) ? 8'h02 : 8'hF4;
                            da = (dc != 0); dw = (dc == 2);
                            e = exp_len(rd[0], rg[0], b2[0], wd, da, dw);
                            if (rg != 0)
                                tag = (e != 0) ? "R6 irq write window" : "R7 plain register access";
                            else if (e == 0) tag = "R8 byte without window";
                            else if (!da) tag = "R3 idle DMA window";
                            else if (!dw) tag = "R4 16-bit DMA window";
                            else tag = "R5 32-bit DMA window";
                            access(rd[0], rg[0], b2[0], wd, da, dw, ws[0] ^ rd[0], 0, n);
                            chk(tag, n, e);
                        end

        // R1: strobes while select high do nothing
        @(negedge clk);
        host_sel_n = 1'b1; rd_wr = 1'b1; reg_sel = 1'b0; byte2 = 1'b0; dma_act = 1'b0;
        strb_a_n = 1'b0;
        repeat (2) @(negedge clk);
        strb_a_n = 1'b1;
        @(negedge clk);
        host_sel_n = 1'b0;
        measure(n, 0);
        chk("R1 no access without select", n, 0);
        access(1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 0, n);
        chk("R1 second strobe alone", n, 5);

        // R2: select lifted mid-window
        access(1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 3, n);
        chk("R2 window length kept", n, 5);

        // R11 / R6 interrupt flags
        @(negedge clk); dsp_ack = 1'b1;
        @(negedge clk); dsp_ack = 1'b0;
        chk("R11 dsp_irq acked", int'(dsp_irq), 0);
        core_irq = 1'b1;
        @(negedge clk); core_irq = 1'b0;
        chk("R11 host_irq set", int'(host_irq), 1);
        access(1'b0, 1'b1, 1'b0, 8'h02, 1'b0, 1'b0, 1'b0, 0, n);
        chk("R6 host bit window", n, 3);
        chk("R6 host_irq cleared", int'(host_irq), 0);
        access(1'b0, 1'b1, 1'b0, 8'h01, 1'b0, 1'b0, 1'b0, 0, n);
        chk("R6 dsp bit window", n, 3);
        chk("R6 dsp_irq set", int'(dsp_irq), 1);
        @(negedge clk); dsp_ack = 1'b1; core_irq = 1'b1;
        @(negedge clk); dsp_ack = 1'b0; core_irq = 1'b0;
        chk("R11 dsp_irq cleared by ack", int'(dsp_irq), 0);
        chk("R11 host_irq set again", int'(host_irq), 1);

        // R7: plain control write updates fields without a wait
        access(1'b0, 1'b1, 1'b0, 8'hA4, 1'b1, 1'b1, 1'b0, 0, n);
        chk("R7 plain write no wait", n, 0);
        chk("R7 ctl_cfg loaded", int'(ctl_cfg), 8'hA4);
        access(1'b1, 1'b1, 1'b0, 8'h5B, 1'b1, 1'b1, 1'b0, 0, n);
        chk("R7 control read no wait", n, 0);
        chk("R7 ctl_cfg kept on read", int'(ctl_cfg), 8'hA4);

        // R9: strobe inside a window is refused
        access(1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1, n);
        chk("R9 window not extended", n, 5);
        measure(n, 0);
        chk("R9 no window after refused strobe", n, 0);
        chk("R9 dsp_irq untouched", int'(dsp_irq), 0);
        chk("R9 ctl_cfg untouched", int'(ctl_cfg), 8'hA4);

        // R10: DMA sampled at the end, frozen afterwards
        access(1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 2, n);
        chk("R10 length frozen at end", n, 13);

        // R12: reset in the middle of a window
        @(negedge clk);
        rd_wr = 1'b1; reg_sel = 1'b0; byte2 = 1'b0; dma_act = 1'b1; dma_32 = 1'b1;
        strb_a_n = 1'b0;
        repeat (2) @(negedge clk);
        strb_a_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R12 window running", int'(rdy), 0);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R12 rdy after mid reset", int'(rdy), 1);
        chk("R12 host_irq after mid reset", int'(host_irq), 0);
        chk("R12 ctl_cfg after mid reset", int'(ctl_cfg), 0);
        measure(n, 0);
        chk("R12 no leftover window", n, 0);

        finish_run();
    end

endmodule